// File: doc/BRIEF.md
# Priority Interrupt Controller with Priority Stack

This block collects a set of level-sensitive interrupt request lines and drives a single registered interrupt line to a processor. Each source has a programmable 4-bit priority. The controller also keeps a current priority level. A source can raise the processor line only if its priority is strictly above that level. When several sources qualify, the controller picks the highest priority and, on a tie, the lowest index. It latches that source as the presented vector.

Software services the line by reading an acknowledge register. The read returns a vector-table base combined with the number of the presented source. The same read drops the processor line, saves the current level on a hardware stack and raises the level to the priority of the acknowledged source. When the handler finishes, it writes the end-of-interrupt register. That write restores the saved level from the stack. Nested interrupts of strictly higher priority can therefore preempt a running handler. The presented vector stays fixed from assertion until acknowledge, even if a higher-priority request arrives in between.

Everything is accessed over a simple synchronous word-addressed register bus with separate read and write strobes. Read data appears on the cycle after the read strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset: irq_o is 0, the current priority is 0, the stack error flag is 0, and every source priority is 0.
- R2: Register map by word address:
  - 0 is the current priority register: bits [3:0] are the priority and are writable; bit 31 is the sticky stack error and is read-only.
  - 1 is the acknowledge register.
  - 2 is the end-of-interrupt register.
  - 3 is the vector base register: the upper BASE_W bits are stored and the lower bits read 0.
  - 16+i is the priority of source i in bits [3:0].
- R3: Priority 0 disables a source. Among the requesting, enabled sources, the highest priority wins, and on equal priority the lowest index wins.
- R4: A source whose priority is equal to or below the current priority never asserts irq_o.
- R5: irq_o is registered. It rises at the first clock edge at which an unmasked request is present, so it rises one cycle after an end-of-interrupt write or a priority write unmasks a pending source.
- R6: The acknowledge read value is {base, vector number, 2'b00}. With BASE_W=21 the vector sits in bits [10:2]; with BASE_W=20 it sits in bits [11:2].
- R7: An acknowledge read while irq_o is high does three things on that edge: it clears irq_o, pushes the current priority onto the stack, and loads the current priority with the acknowledged source's priority.
- R8: While irq_o is high, it stays high and the presented vector does not change, even if a higher-priority request arrives or the presented request is withdrawn.
- R9: Any write to the end-of-interrupt register pops the stack top into the current priority, whatever data is written. That register always reads 0.
- R10: An acknowledge read while irq_o is low has no side effect: the current priority and the stack stay unchanged.
- R11: The stack holds 15 entries. A push while full sets the error flag and leaves the stack unchanged, but the acknowledge still loads the current priority.
- R12: A pop while the stack is empty loads priority 0 and sets the error flag.
- R13: The error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_SRC | Level-sensitive source requests |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The arbitration tests use several patterns, and each one separates a different rule:
- a single source, to confirm the basic path;
- two sources at equal priority at opposite index ends, which separates the lowest-index tie rule from a highest-index rule;
- a high-priority source against a low-priority one, to confirm that priority order wins;
- sources at, below and above the current level, which separates strict masking from a less-or-equal comparison.

A late higher-priority arrival and a withdrawn request show whether the presented vector is truly frozen until it is acknowledged. Nested acknowledge and end-of-interrupt sequences, a full fill of the stack to overflow, and a pop on an empty stack confirm last-in-first-out order, the unchanged contents after overflow, and the sticky error flag.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned REG_CUR  = 0;
  localparam int unsigned REG_ACK  = 1;
  localparam int unsigned REG_EOI  = 2;
  localparam int unsigned REG_BASE = 3;
  localparam int unsigned REG_SRC0 = 16;
endpackage

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]        win_idx_o,
  output logic [PRIO_W-1:0]       win_prio_o,
  output logic                    win_valid_o
);
  // descending scan with >= lets the lowest index win ties
  always_comb begin
    win_idx_o  = '0;
    win_prio_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] != '0) &&
          (prio_i[i*PRIO_W +: PRIO_W] >= win_prio_o)) begin
        win_idx_o  = IDX_W'(i);
        win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
    win_valid_o = (win_prio_o != '0);
  end
endmodule

// File: rtl/prio_stack.sv
module prio_stack #(
  parameter int unsigned DEPTH  = 15,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] push_data_i,
  output logic [PRIO_W-1:0] pop_data_o,
  output logic              err_o
);
  logic [PRIO_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;
  logic              full, empty;

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign empty      = (cnt_q == '0);
  assign pop_data_o = empty ? '0 : mem_q[PTR_W'(cnt_q - 1'b1)];
  assign err_o      = err_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem_q[PTR_W'(cnt_q)] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (push_i && !full)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !empty) cnt_q <= cnt_q - 1'b1;
      if ((push_i && full) || (pop_i && empty)) err_q <= 1'b1;
    end
  end

  // R11
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full |=> cnt_q == $past(cnt_q));
  // R11
  err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full) || (pop_i && empty) |=> err_q);
  // R13
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  // R11
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned PRIO_W      = 4,
  parameter int unsigned STACK_DEPTH = 15,
  parameter int unsigned BASE_W      = 21,
  parameter int unsigned ADDR_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_req_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VEC_W  = DATA_W - BASE_W - 2;
  localparam int unsigned IDX_W  = $clog2(N_SRC);

  logic [PRIO_W-1:0]       src_prio_q [N_SRC];
  logic [N_SRC*PRIO_W-1:0] src_prio_flat;
  logic [PRIO_W-1:0]       cur_q, vec_prio_q, win_prio, pop_data;
  logic [IDX_W-1:0]        vec_q, win_idx;
  logic [BASE_W-1:0]       base_q;
  logic                    irq_q, win_valid, cand_ok, stk_err;
  logic                    hit_cur, hit_ack, hit_eoi, hit_base, hit_src;
  logic [ADDR_W-1:0]       src_off;
  logic                    ack_fire, eoi_fire;
  logic [DATA_W-1:0]       rd_mux, rdata_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_flat
    assign src_prio_flat[g*PRIO_W +: PRIO_W] = src_prio_q[g];
  end

  assign hit_cur  = (bus_addr_i == ADDR_W'(REG_CUR));
  assign hit_ack  = (bus_addr_i == ADDR_W'(REG_ACK));
  assign hit_eoi  = (bus_addr_i == ADDR_W'(REG_EOI));
  assign hit_base = (bus_addr_i == ADDR_W'(REG_BASE));
  assign src_off  = bus_addr_i - ADDR_W'(REG_SRC0);
  assign hit_src  = (bus_addr_i >= ADDR_W'(REG_SRC0)) && (src_off < ADDR_W'(N_SRC));

  assign ack_fire = bus_rd_i && hit_ack && irq_q;
  assign eoi_fire = bus_wr_i && hit_eoi && !ack_fire;

  prio_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) i_arb (
    .req_i      (irq_req_i),
    .prio_i     (src_prio_flat),
    .win_idx_o  (win_idx),
    .win_prio_o (win_prio),
    .win_valid_o(win_valid)
  );

  prio_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) i_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ack_fire),
    .pop_i      (eoi_fire),
    .push_data_i(cur_q),
    .pop_data_o (pop_data),
    .err_o      (stk_err)
  );

  assign cand_ok = win_valid && (win_prio > cur_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q      <= 1'b0;
      vec_q      <= '0;
      vec_prio_q <= '0;
      cur_q      <= '0;
      base_q     <= '0;
      for (int i = 0; i < N_SRC; i++) src_prio_q[i] <= '0;
    end else begin
      // presented vector frozen while irq_q is high
      if (irq_q) begin
        irq_q <= !ack_fire;
      end else if (cand_ok) begin
        irq_q      <= 1'b1;
        vec_q      <= win_idx;
        vec_prio_q <= win_prio;
      end
      if (ack_fire)                  cur_q <= vec_prio_q;
      else if (eoi_fire)             cur_q <= pop_data;
      else if (bus_wr_i && hit_cur)  cur_q <= bus_wdata_i[PRIO_W-1:0];
      if (bus_wr_i && hit_base) base_q <= bus_wdata_i[DATA_W-1 -: BASE_W];
      if (bus_wr_i && hit_src)  src_prio_q[IDX_W'(src_off)] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cur)       rd_mux = {stk_err, {(DATA_W-1-PRIO_W){1'b0}}, cur_q};
    else if (hit_ack)  rd_mux = {base_q, VEC_W'(vec_q), 2'b00};
    else if (hit_base) rd_mux = {base_q, {(DATA_W-BASE_W){1'b0}}};
    else if (hit_src)  rd_mux = {{(DATA_W-PRIO_W){1'b0}}, src_prio_q[IDX_W'(src_off)]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;

  // R7
  ack_negate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> !irq_q);
  // R7
  ack_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> cur_q == $past(vec_prio_q));
  // R8
  vec_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !ack_fire |=> irq_q && $stable(vec_q) && $stable(vec_prio_q));
  // R4
  rise_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (vec_prio_q > $past(cur_q)) && (vec_prio_q != '0));
  // R10
  idle_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_i && hit_ack && !irq_q && !bus_wr_i |=> $stable(cur_q));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int N = 8;
  localparam logic [5:0] A_CUR = 6'd0, A_ACK = 6'd1, A_EOI = 6'd2, A_BASE = 6'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, fails = 0;
  logic [31:0] base_val = 32'hA5A5_F800;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req_tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  function automatic logic [31:0] ack_val(int idx);
    return (base_val & 32'hFFFF_F800) | (32'(idx) << 2);
  endfunction

  task automatic do_reset();
    req = '0; wr = 1'b0; rd = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    bus_wr(A_BASE, base_val);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    bus_rd(A_CUR, d);  check("R1 cur/err", d, 0);
    bus_rd(6'd20, d);  check("R1 src prio", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_wr(A_BASE, 32'hFFFF_FFFF);
    bus_rd(A_BASE, d); check("R2 base", d, 32'hFFFF_F800);
    bus_wr(A_BASE, base_val);
    bus_wr(6'd21, 32'hFFFF_FFF9);
    bus_rd(6'd21, d);  check("R2 src5 prio", d, 9);
    bus_wr(6'd21, 0);
    bus_wr(A_CUR, 32'h0000_0007);
    bus_rd(A_CUR, d);  check("R2 cur write", d, 7);
    bus_wr(A_CUR, 0);
    bus_rd(A_EOI, d);  check("R9 eoi reads 0", d, 0);
  endtask

  task automatic t_single();
    logic [31:0] d;
    do_reset();
    bus_wr(6'd19, 5);
    req[3] = 1'b1;
    check("R5 no irq same cycle", {31'b0, irq}, 0);
    @(negedge clk);
    check("R5 irq rises", {31'b0, irq}, 1);
    bus_rd(A_ACK, d);
    check("R6 ack value", d, ack_val(3));
    check("R7 irq cleared", {31'b0, irq}, 0);
    bus_rd(A_CUR, d);  check("R7 cur raised", d, 5);
    // masking at equal and lower priority
    req[3] = 1'b0;
    bus_wr(6'd18, 5); bus_wr(6'd17, 4);
    req[2] = 1'b1; req[1] = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 masked at/below cur", {31'b0, irq}, 0);
    bus_wr(A_EOI, 32'hFFFF_FFFF);
    check("R5 not yet after eoi", {31'b0, irq}, 0);
    bus_rd(A_CUR, d);  check("R9 eoi pop ignores data", d, 0);
    check("R5 irq after eoi", {31'b0, irq}, 1);
    bus_rd(A_ACK, d);  check("R3 higher prio wins", d, ack_val(2));
  endtask

  task automatic t_arb();
    logic [31:0] d;
    do_reset();
    bus_wr(6'd17, 7); bus_wr(6'd22, 7);
    req[1] = 1'b1; req[6] = 1'b1;
    @(negedge clk);
    bus_rd(A_ACK, d);  check("R3 tie lowest index", d, ack_val(1));
    do_reset();
    bus_wr(6'd16, 3); bus_wr(6'd21, 9); bus_wr(6'd23, 0);
    req[0] = 1'b1; req[5] = 1'b1; req[7] = 1'b1;
    @(negedge clk);
    bus_rd(A_ACK, d);  check("R3 priority order", d, ack_val(5));
    do_reset();
    req[7] = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 prio 0 disabled", {31'b0, irq}, 0);
  endtask

  task automatic t_frozen();
    logic [31:0] d;
    do_reset();
    bus_wr(6'd20, 2); bus_wr(6'd23, 12);
    req[4] = 1'b1;
    @(negedge clk);
    check("R8 irq for src4", {31'b0, irq}, 1);
    req[7] = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 irq held", {31'b0, irq}, 1);
    bus_rd(A_ACK, d);  check("R8 vector frozen", d, ack_val(4));
    bus_rd(A_CUR, d);  check("R7 cur=2", d, 2);
    check("R5 nested irq", {31'b0, irq}, 1);
    bus_rd(A_ACK, d);  check("R6 nested vector", d, ack_val(7));
    req = '0;
    bus_wr(A_EOI, 0);
    bus_rd(A_CUR, d);  check("R9 pop to 2", d, 2);
    bus_wr(A_EOI, 0);
    bus_rd(A_CUR, d);  check("R9 pop to 0", d, 0);
    // withdrawn request stays presented
    req[4] = 1'b1;
    @(negedge clk);
    req[4] = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 irq held after withdraw", {31'b0, irq}, 1);
    bus_rd(A_ACK, d);  check("R8 withdrawn vector", d, ack_val(4));
    // idle ack read has no side effect
    bus_rd(A_ACK, d);
    bus_rd(A_CUR, d);  check("R10 idle ack no effect", d, 2);
    bus_wr(A_EOI, 0);
    bus_rd(A_CUR, d);  check("R10 stack untouched", d, 0);
    bus_rd(A_CUR, d);  check("R10 no err", d, 0);
  endtask

  task automatic t_underflow();
    logic [31:0] d;
    do_reset();
    bus_wr(A_CUR, 9);
    bus_wr(A_EOI, 0);
    bus_rd(A_CUR, d);  check("R12 empty pop", d, 32'h8000_0000);
    bus_wr(A_CUR, 4);
    bus_rd(A_CUR, d);  check("R13 err sticky", d, 32'h8000_0004);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    do_reset();
    bus_wr(6'd16, 15);
    req[0] = 1'b1;
    for (int i = 0; i < 15; i++) begin
      bus_wr(A_CUR, 32'(i));
      @(negedge clk);
      bus_rd(A_ACK, d);
    end
    bus_rd(A_CUR, d);  check("R11 full no err", d, 15);
    bus_wr(A_CUR, 3);
    @(negedge clk);
    bus_rd(A_ACK, d);
    bus_rd(A_CUR, d);  check("R11 overflow err, cur loaded", d, 32'h8000_000F);
    req = '0;
    for (int i = 14; i >= 0; i--) begin
      bus_wr(A_EOI, 0);
      bus_rd(A_CUR, d);
      check("R11 contents kept", d, 32'h8000_0000 | 32'(i));
    end
    do_reset();
    bus_rd(A_CUR, d);  check("R13 reset clears err", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    base_val = 32'hA5A5_F800;
    t_regs();
    t_single();
    t_arb();
    t_frozen();
    t_underflow();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule